// File: doc/BRIEF.md
# Sleep-Mode Entry and Exit Sequencer

This block controls the low-power sleep state of a synchronous memory model. A sleep request arrives on a pin with no timing relation to the clock. The block synchronizes that pin to the clock and then steps through a fixed entry sequence and a fixed exit sequence. At the end of the exit sequence it holds a recovery window before it lets accesses through again. The access logic that sits next to it reads three things: a sleep flag, an access-valid qualifier that is raised only while the memory is fully awake, and the current sequencer state.

Any access that is in flight when the memory starts going to sleep is dropped, because the qualifier falls as soon as the state leaves AWAKE. Stored contents live in the array outside this block and are not touched by it. Two sticky flags record protocol misuse:
- The device was still selected when the sleep request took effect.
- An address strobe arrived while the memory was waking up.

Each flag stays set until reset.

Top module: `sleep_seq`

## Requirements
- R1: While reset is asserted and right after it is released, `state_o` is 0 (AWAKE), `sleep_active` is 0, `access_ok` is 0 and `violation` is 2'b00.
- R2: The sleep request passes through a two-flop synchronizer. If `sleep_req` rises before rising edge n, `state_o` leaves 0 and becomes 1 (ENTERING) after edge n+2.
- R3: ENTERING (1) lasts exactly two cycles and is followed by ASLEEP (2). `sleep_active` is 1 only while `state_o` is 2.
- R4: In ASLEEP, if `sleep_req` falls before edge n, the state becomes 3 (EXITING) after edge n+2. EXITING lasts two cycles. RECOVERY (4) follows and also lasts two cycles. The state then returns to 0.
- R5: `access_ok` is 1 only when all three of these hold: the state is 0, every bit of `chip_en` is 1, and at least one of `strobe_a` and `strobe_b` is 1. In every other state, strobes are ignored and `access_ok` is 0.
- R6: `violation[0]` is set at the edge where the state moves from 0 to 1, if every `chip_en` bit is 1 in that cycle. It stays set until reset.
- R7: `violation[1]` is set at the edge that ends any cycle in state 3 or 4 with a strobe high. It stays set until reset. A strobe in state 1 or 2 does not set it.
- R8: Once ENTERING has started, it always completes to ASLEEP, even if the request drops during ENTERING. The state then goes on to EXITING.
- R9: If the request is raised again during EXITING or RECOVERY, the exit sequence still finishes to AWAKE. ENTERING then starts one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| sleep_req | input | 1 | Sleep request, asynchronous to clk, active high |
| chip_en | input | NUM_CE | Chip enables, active high; the device is selected when all are 1 |
| strobe_a | input | 1 | First address strobe, active high |
| strobe_b | input | 1 | Second address strobe, active high |
| state_o | output | 3 | Sequencer state: 0 AWAKE, 1 ENTERING, 2 ASLEEP, 3 EXITING, 4 RECOVERY |
| sleep_active | output | 1 | High while asleep |
| access_ok | output | 1 | Qualified access, valid only when awake |
| violation | output | 2 | Sticky flags: bit 0 selected at entry, bit 1 strobe during wake-up |

## Verification
The assertions check on every cycle that the state moves only along legal transitions, that ENTERING starts with a full second cycle, that the qualifier never rises outside AWAKE, that the sleep flag rises only out of ENTERING, and that both violation flags stay set once set. The exact cycle counts from the asynchronous pin edge are shown only by the bench's timed scenarios. The same holds for the combined qualifier truth table, for the sequence continuing when the request drops or returns mid-sequence, and for a strobe while asleep leaving the flags clear.

// File: rtl/sleep_pkg.sv
package sleep_pkg;
    typedef enum logic [2:0] {
        ST_AWAKE  = 3'd0,
        ST_ENTER  = 3'd1,
        ST_ASLEEP = 3'd2,
        ST_EXIT   = 3'd3,
        ST_RECOV  = 3'd4
    } slp_state_e;
endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_async};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
    import sleep_pkg::*;
#(
    parameter int ENTRY_CYC = 2,
    parameter int EXIT_CYC  = 2,
    parameter int RECOV_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_sync,
    output slp_state_e state
);
    localparam int MAXC  = (ENTRY_CYC > EXIT_CYC)
                         ? ((ENTRY_CYC > RECOV_CYC) ? ENTRY_CYC : RECOV_CYC)
                         : ((EXIT_CYC > RECOV_CYC) ? EXIT_CYC : RECOV_CYC);
    localparam int CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);
    localparam logic [CNT_W-1:0] ENTRY_LD = CNT_W'(ENTRY_CYC - 1);
    localparam logic [CNT_W-1:0] EXIT_LD  = CNT_W'(EXIT_CYC - 1);
    localparam logic [CNT_W-1:0] RECOV_LD = CNT_W'(RECOV_CYC - 1);

    typedef struct packed {
        slp_state_e       st;
        logic [CNT_W-1:0] cnt;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        case (fsm_q.st)
            ST_AWAKE: begin
                if (req_sync) begin
                    fsm_d.st  = ST_ENTER;
                    fsm_d.cnt = ENTRY_LD;
                end
            end
            ST_ENTER: begin
                if (fsm_q.cnt == '0) fsm_d.st = ST_ASLEEP;
                else                 fsm_d.cnt = fsm_q.cnt - 1'b1;
            end
            ST_ASLEEP: begin
                if (!req_sync) begin
                    fsm_d.st  = ST_EXIT;
                    fsm_d.cnt = EXIT_LD;
                end
            end
            ST_EXIT: begin
                if (fsm_q.cnt == '0) begin
                    fsm_d.st  = ST_RECOV;
                    fsm_d.cnt = RECOV_LD;
                end else begin
                    fsm_d.cnt = fsm_q.cnt - 1'b1;
                end
            end
            ST_RECOV: begin
                if (fsm_q.cnt == '0) fsm_d.st = ST_AWAKE;
                else                 fsm_d.cnt = fsm_q.cnt - 1'b1;
            end
            default: begin
                fsm_d.st  = ST_AWAKE;
                fsm_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st  <= ST_AWAKE;
            fsm_q.cnt <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state = fsm_q.st;
endmodule

// File: rtl/slp_guard.sv
module slp_guard
    import sleep_pkg::*;
#(
    parameter int NUM_CE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slp_state_e        state,
    input  logic              req_sync,
    input  logic [NUM_CE-1:0] chip_en,
    input  logic              strobe_a,
    input  logic              strobe_b,
    output logic [1:0]        flags
);
    typedef struct packed {
        logic early_err;
        logic sel_err;
    } guard_t;

    guard_t g_d, g_q;
    logic   selected;
    logic   waking;

    always_comb begin
        selected = &chip_en;
        waking   = (state == ST_EXIT) || (state == ST_RECOV);
        g_d      = g_q;
        if ((state == ST_AWAKE) && req_sync && selected) g_d.sel_err = 1'b1;
        if (waking && (strobe_a || strobe_b))            g_d.early_err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign flags = {g_q.early_err, g_q.sel_err};
endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
    import sleep_pkg::*;
#(
    parameter int NUM_CE      = 3,
    parameter int SYNC_STAGES = 2,
    parameter int ENTRY_CYC   = 2,
    parameter int EXIT_CYC    = 2,
    parameter int RECOV_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic [NUM_CE-1:0] chip_en,
    input  logic              strobe_a,
    input  logic              strobe_b,
    output logic [2:0]        state_o,
    output logic              sleep_active,
    output logic              access_ok,
    output logic [1:0]        violation
);
    logic       req_sync;
    slp_state_e state;

    slp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (sleep_req),
        .q       (req_sync)
    );

    slp_fsm #(
        .ENTRY_CYC (ENTRY_CYC),
        .EXIT_CYC  (EXIT_CYC),
        .RECOV_CYC (RECOV_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_sync (req_sync),
        .state    (state)
    );

    slp_guard #(.NUM_CE(NUM_CE)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .req_sync (req_sync),
        .chip_en  (chip_en),
        .strobe_a (strobe_a),
        .strobe_b (strobe_b),
        .flags    (violation)
    );

    always_comb begin
        state_o      = state;
        sleep_active = (state == ST_ASLEEP);
        access_ok    = (state == ST_AWAKE) && (&chip_en) && (strobe_a || strobe_b);
    end
endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] state_o,
    input logic       sleep_active,
    input logic       access_ok,
    input logic [1:0] violation
);
    p_awake_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0) |=> (state_o == 3'd0 || state_o == 3'd1));

    p_entry_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && $past(state_o) == 3'd0) |=> (state_o == 3'd1));

    p_sleep_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_active) |-> ($past(state_o) == 3'd1));

    p_asleep_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2) |=> (state_o == 3'd2 || state_o == 3'd3));

    p_recov_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4) |=> (state_o == 3'd4 || state_o == 3'd0));

    p_access_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        access_ok |-> (state_o == 3'd0));

    p_sel_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        violation[0] |=> violation[0]);

    p_early_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        violation[1] |=> violation[1]);
endmodule

bind sleep_seq sleep_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_o      (state_o),
    .sleep_active (sleep_active),
    .access_ok    (access_ok),
    .violation    (violation)
);

// File: tb/tb_sleep_seq.sv
`timescale 1ns/1ps
module tb_sleep_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic [2:0] chip_en = 3'b000;
    logic       strobe_a = 1'b0;
    logic       strobe_b = 1'b0;
    logic [2:0] state_o;
    logic       sleep_active;
    logic       access_ok;
    logic [1:0] violation;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    sleep_seq dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_req    (sleep_req),
        .chip_en      (chip_en),
        .strobe_a     (strobe_a),
        .strobe_b     (strobe_b),
        .state_o      (state_o),
        .sleep_active (sleep_active),
        .access_ok    (access_ok),
        .violation    (violation)
    );

    // vector: {chip_en[2:0], strobe_a, strobe_b, expected access_ok}
    localparam logic [5:0] VEC [8] = '{
        6'b111_10_1, 6'b111_01_1, 6'b111_11_1, 6'b111_00_0,
        6'b110_10_0, 6'b011_01_0, 6'b000_11_0, 6'b101_11_0
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sleep_req = 1'b0; chip_en = 3'b000; strobe_a = 1'b0; strobe_b = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        #400us;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog all-reqs actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: values while reset is held
        chk("R1 state in reset", state_o, 0);
        chk("R1 violation in reset", violation, 0);
        do_reset();
        chk("R1 state", state_o, 0);
        chk("R1 sleep_active", sleep_active, 0);
        chk("R1 access_ok", access_ok, 0);
        chk("R1 violation", violation, 0);

        // R5 qualifier table in AWAKE
        foreach (VEC[i]) begin
            chip_en = VEC[i][5:3]; strobe_a = VEC[i][2]; strobe_b = VEC[i][1];
            #1;
            chk("R5 access_ok table", access_ok, VEC[i][0]);
            tick();
        end
        chk("R6 no flag without request", violation, 0);
        chip_en = 3'b000; strobe_a = 0; strobe_b = 0;

        // R2/R3: entry timing
        sleep_req = 1'b1;
        tick(); chk("R2 edge1 still awake", state_o, 0);
        tick(); chk("R2 edge2 still awake", state_o, 0);
        tick(); chk("R2 edge3 entering", state_o, 1);
        chk("R3 no sleep flag in entering", sleep_active, 0);
        tick(); chk("R3 entering second cycle", state_o, 1);
        tick(); chk("R3 asleep", state_o, 2);
        chk("R3 sleep flag", sleep_active, 1);
        // R5/R7: strobes while asleep are ignored
        chip_en = 3'b111; strobe_a = 1; strobe_b = 1;
        #1; chk("R5 access_ok blocked asleep", access_ok, 0);
        tick(); chk("R7 strobe asleep no flag", violation, 0);
        chip_en = 3'b000; strobe_a = 0; strobe_b = 0;

        // R4: exit timing
        sleep_req = 1'b0;
        tick(); chk("R4 edge1 asleep", state_o, 2);
        tick(); chk("R4 edge2 asleep", state_o, 2);
        tick(); chk("R4 exiting", state_o, 3);
        tick(); chk("R4 exiting second", state_o, 3);
        tick(); chk("R4 recovery", state_o, 4);
        tick(); chk("R4 recovery second", state_o, 4);
        tick(); chk("R4 awake", state_o, 0);
        chk("R4 no violation clean cycle", violation, 0);

        // R7: strobe during recovery
        sleep_req = 1'b1;
        repeat (5) tick();
        chk("R7 setup asleep", state_o, 2);
        sleep_req = 1'b0;
        repeat (5) tick();
        chk("R7 setup recovery", state_o, 4);
        strobe_b = 1'b1;
        #1; chk("R5 access_ok blocked recovery", access_ok, 0);
        tick(); strobe_b = 1'b0;
        chk("R7 early strobe flag", violation, 2);
        repeat (3) tick();
        chk("R7 sticky after awake", violation, 2);
        do_reset();
        chk("R1 reset clears flags", violation, 0);

        // R6: still selected at entry
        chip_en = 3'b111;
        sleep_req = 1'b1;
        tick(); tick();
        chk("R6 not yet set", violation, 0);
        tick();
        chk("R6 entry state", state_o, 1);
        chk("R6 selected at entry", violation, 1);
        chip_en = 3'b000;
        sleep_req = 1'b0;
        repeat (10) tick();
        chk("R6 sticky", violation, 1);
        do_reset();

        // R8: request dropped during ENTERING
        sleep_req = 1'b1;
        repeat (3) tick();
        chk("R8 entering", state_o, 1);
        sleep_req = 1'b0;
        tick(); chk("R8 entering continues", state_o, 1);
        tick(); chk("R8 reaches asleep", state_o, 2);
        tick(); chk("R8 then exits", state_o, 3);
        repeat (4) tick();
        chk("R8 back awake", state_o, 0);

        // R9: request returns during EXITING
        sleep_req = 1'b1;
        repeat (5) tick();
        sleep_req = 1'b0;
        repeat (3) tick();
        chk("R9 exiting", state_o, 3);
        sleep_req = 1'b1;
        tick(); chk("R9 exit continues", state_o, 3);
        tick(); chk("R9 recovery", state_o, 4);
        tick(); chk("R9 recovery second", state_o, 4);
        tick(); chk("R9 awake", state_o, 0);
        tick(); chk("R9 re-enter", state_o, 1);
        chk("R9 no violation", violation, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule